// File: doc/BRIEF.md
# Audio Clock Ratio Mode Detector

This block measures how many master clock cycles fit into one period of the left/right frame clock. It sorts that count into one of five supported ratios and, from the ratio, picks a base-rate or high-rate operating mode for a stereo oversampling converter. Once the ratio has held steady for several frames, it raises a lock flag. While locked, it produces two single-cycle enables in the master clock domain. One paces the 4x interpolated sample stream. The other paces the 1-bit modulator, which runs at 128 times the sample rate in base-rate mode and 64 times in high-rate mode.

The frame clock may be asynchronous to the master clock. It passes through a two-flop synchroniser before its rising edges are detected. No data flows through the block, so it has no valid/ready interface and no back-pressure. Every pin is a plain control or status signal. The enables are meant for downstream datapath stages that already run on the master clock.

Top module: `clk_ratio_mode_detect`

## Requirements
- R1: The frame period is the number of master clock cycles between two consecutive rising frame clock edges, seen after a two-flop synchroniser. The first rising edge after reset only starts a measurement and produces no result.
- R2: A period within ±2 cycles of 128, 192, 256, 384 or 512 is classified as ratio code 0, 1, 2, 3 or 4 respectively. Any other period is unsupported. This includes periods too long for the counter, which saturates instead of wrapping.
- R3: `locked` rises once 4 consecutive measured frames give the same supported ratio code.
- R4: `locked` falls at once on any measured frame whose ratio is unsupported or differs from the frame before it.
- R5: `hi_rate` is 1 for codes 0 and 1 and 0 for codes 2 to 4. `ratio_code` and `hi_rate` are loaded only when lock is gained. They keep their values while unlocked.
- R6: While locked, `mod_en` pulses for one cycle every ratio/128 master clocks when `hi_rate` is 0, and every ratio/64 master clocks when `hi_rate` is 1.
- R7: While locked, `interp_en` pulses for one cycle every ratio/4 master clocks.
- R8: While `locked` is 0, `mod_en` and `interp_en` are both 0.
- R9: After reset, `locked` is 0, `ratio_code` is 2 and `hi_rate` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Left/right frame clock, asynchronous |
| ratio_code | output | 3 | Locked ratio code (0:128, 1:192, 2:256, 3:384, 4:512) |
| hi_rate | output | 1 | 1 = high-rate mode, 0 = base-rate mode |
| locked | output | 1 | Ratio stable and supported |
| interp_en | output | 1 | Single-cycle enable at 4 times the frame rate |
| mod_en | output | 1 | Single-cycle enable at the modulator bit rate |

## Verification
Suppose the period counter or the classifier holds a wrong value. The result is a wrong `ratio_code` or `hi_rate`, or a lock that arrives early, late or never. It shows at the end of the frame after the faulty measurement, because each measurement closes on the next rising edge. A wrong lock streak shows up just as quickly as an early or a missing `locked`. A fault in a divider counter shows within a single enable period as a gap that differs from ratio/4 or from the modulator divisor. The bench sweeps every supported ratio at offsets of up to ±3 cycles and runs ratio changes, unsupported frames and an over-long frame. It compares each frame against an arithmetic model and times every enable pulse.

// File: rtl/rate_sense_pkg.sv
package rate_sense_pkg;

  typedef enum logic [2:0] {
    RC_128  = 3'd0,
    RC_192  = 3'd1,
    RC_256  = 3'd2,
    RC_384  = 3'd3,
    RC_512  = 3'd4,
    RC_NONE = 3'd7
  } ratio_e;

  localparam int NUM_RATIOS = 5;

  function automatic int nominal(input ratio_e c);
    case (c)
      RC_128:  return 128;
      RC_192:  return 192;
      RC_256:  return 256;
      RC_384:  return 384;
      RC_512:  return 512;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_high(input ratio_e c);
    return (c == RC_128) || (c == RC_192);
  endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= async_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= 1'b0;
      else        pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R1: a detected edge is never reported on two cycles in a row
  a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/rate_period_meter.sv
module rate_period_meter
  import rate_sense_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise_i,
  output logic   meas_valid_o,
  output ratio_e meas_code_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;
  ratio_e           cls;

  always_comb begin
    int c;
    int n;
    c   = int'(cnt_q);
    cls = RC_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      n = nominal(ratio_e'(3'(i)));
      if ((c + TOL >= n) && (c <= n + TOL)) cls = ratio_e'(3'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      primed_q     <= 1'b0;
      meas_valid_o <= 1'b0;
      meas_code_o  <= RC_NONE;
    end else begin
      meas_valid_o <= 1'b0;
      if (rise_i) begin
        cnt_q    <= CNT_W'(1);
        primed_q <= 1'b1;
        if (primed_q) begin
          meas_valid_o <= 1'b1;
          meas_code_o  <= cls;
        end
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1: a result appears only on the cycle after a detected edge
  a_r1_meas_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid_o |-> $past(rise_i));
  // R2: a saturated counter stays saturated until the next edge
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !rise_i) |=> cnt_q == '1);

endmodule

// File: rtl/rate_lock_tracker.sv
module rate_lock_tracker
  import rate_sense_pkg::*;
#(
  parameter int LOCK_FRAMES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   meas_valid_i,
  input  ratio_e meas_code_i,
  output logic   locked_o,
  output ratio_e ratio_o,
  output logic   hi_rate_o
);
  localparam int SW = $clog2(LOCK_FRAMES + 1);

  ratio_e        last_q;
  logic [SW-1:0] streak_q, streak_n;

  always_comb begin
    if (meas_code_i == RC_NONE)
      streak_n = '0;
    else if (meas_code_i == last_q && streak_q != '0)
      streak_n = (streak_q >= SW'(LOCK_FRAMES)) ? streak_q : streak_q + 1'b1;
    else
      streak_n = SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= RC_NONE;
      streak_q  <= '0;
      locked_o  <= 1'b0;
      ratio_o   <= RC_256;
      hi_rate_o <= 1'b0;
    end else if (meas_valid_i) begin
      last_q   <= meas_code_i;
      streak_q <= streak_n;
      locked_o <= (streak_n >= SW'(LOCK_FRAMES));
      if (streak_n >= SW'(LOCK_FRAMES)) begin
        ratio_o   <= meas_code_i;
        hi_rate_o <= is_high(meas_code_i);
      end
    end
  end

  // R4: an unsupported frame drops lock on the next cycle
  a_r4_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid_i && meas_code_i == RC_NONE) |=> !locked_o);
  // R5: mode and ratio hold while unlocked
  a_r5_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> ($stable(hi_rate_o) && $stable(ratio_o)));
  // R3: lock is only gained on a measurement
  a_r3_lock_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(meas_valid_i));

endmodule

// File: rtl/strobe_div.sv
module strobe_div #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] period_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q == period_i - 1'b1) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = run_i && (cnt_q == period_i - 1'b1);

  // R6: every enable is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rate_sense_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   locked_i,
  input  ratio_e ratio_i,
  input  logic   hi_rate_i,
  output logic   interp_en_o,
  output logic   mod_en_o
);
  localparam int NCH = 2;

  logic [DIV_W-1:0] period [NCH];
  logic [NCH-1:0]   pulse;

  always_comb begin
    int n;
    n = nominal(ratio_i);
    period[0] = DIV_W'(n / 4);
    period[1] = hi_rate_i ? DIV_W'(n / 64) : DIV_W'(n / 128);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    strobe_div #(.W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (locked_i),
      .period_i (period[g]),
      .pulse_o  (pulse[g])
    );
  end

  assign interp_en_o = pulse[0];
  assign mod_en_o    = pulse[1];

  // R8: no enable while unlocked
  a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |-> (pulse == '0));

endmodule

// File: rtl/clk_ratio_mode_detect.sv
module clk_ratio_mode_detect
  import rate_sense_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 2,
  parameter int LOCK_FRAMES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  output logic [2:0] ratio_code,
  output logic       hi_rate,
  output logic       locked,
  output logic       interp_en,
  output logic       mod_en
);
  localparam int DIV_W = CNT_W - 1;

  logic   rise;
  logic   meas_valid;
  ratio_e meas_code;
  ratio_e ratio_q;

  frame_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (frame_clk),
    .rise_o  (rise)
  );

  rate_period_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (rise),
    .meas_valid_o (meas_valid),
    .meas_code_o  (meas_code)
  );

  rate_lock_tracker #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_valid_i (meas_valid),
    .meas_code_i  (meas_code),
    .locked_o     (locked),
    .ratio_o      (ratio_q),
    .hi_rate_o    (hi_rate)
  );

  rate_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .locked_i    (locked),
    .ratio_i     (ratio_q),
    .hi_rate_i   (hi_rate),
    .interp_en_o (interp_en),
    .mod_en_o    (mod_en)
  );

  assign ratio_code = ratio_q;

  // R5: a locked ratio is always a supported one and matches the mode
  a_r5_locked_valid: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (ratio_q != RC_NONE && hi_rate == (ratio_code < 3'd2)));

endmodule

// File: tb/tb_clk_ratio_mode_detect.sv
module tb_clk_ratio_mode_detect;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic [2:0] ratio_code;
  logic       hi_rate, locked, interp_en, mod_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  clk_ratio_mode_detect dut (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .ratio_code(ratio_code), .hi_rate(hi_rate), .locked(locked),
    .interp_en(interp_en), .mod_en(mod_en)
  );

  always #(CLK_NS/2) clk = ~clk;

  // arithmetic model of the requirements
  bit m_primed; int m_prev, m_streak, m_last, m_code; bit m_lock, m_hi;

  function automatic int nom_of(input int c);
    return (c == 0) ? 128 : (c == 1) ? 192 : (c == 2) ? 256 : (c == 3) ? 384 : 512;
  endfunction

  function automatic int classify(input int p);
    int r = 7;
    for (int c = 0; c < 5; c++)
      if (p >= nom_of(c) - 2 && p <= nom_of(c) + 2) r = c;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_primed = 0; m_streak = 0; m_last = 7; m_code = 2; m_lock = 0; m_hi = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; frame_clk = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one frame clock period of p master clocks, starting with a rising edge
  task automatic frame(input int p);
    if (m_primed) begin
      int c = classify(m_prev);
      if (c == 7) m_streak = 0;
      else if (c == m_last && m_streak > 0) m_streak = (m_streak >= 4) ? 4 : m_streak + 1;
      else m_streak = 1;
      m_last = c;
      m_lock = (m_streak >= 4);
      if (m_lock) begin m_code = c; m_hi = (c < 2); end
    end
    m_primed = 1; m_prev = p;
    frame_clk = 1'b1;
    repeat (p / 2) @(negedge clk);
    frame_clk = 1'b0;
    repeat (p - p / 2) @(negedge clk);
    chk("R3/R4 locked", int'(locked), int'(m_lock));
    chk("R5 hi_rate", int'(hi_rate), int'(m_hi));
    chk("R2/R5 ratio_code", int'(ratio_code), m_code);
  endtask

  // enable monitor: R6, R7, R8
  int cyc = 0, last_mod = 0, last_int = 0;
  bit have_mod = 0, have_int = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!locked) begin
        have_mod = 0; have_int = 0;
        chk("R8 strobes quiet", int'(mod_en) + int'(interp_en), 0);
      end else begin
        if (mod_en) begin
          if (have_mod)
            chk("R6 mod_en gap", cyc - last_mod,
                (m_code < 2) ? nom_of(m_code) / 64 : nom_of(m_code) / 128);
          have_mod = 1; last_mod = cyc;
        end
        if (interp_en) begin
          if (have_int) chk("R7 interp_en gap", cyc - last_int, nom_of(m_code) / 4);
          have_int = 1; last_int = cyc;
        end
      end
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 locked", int'(locked), 0);
    chk("R9 ratio_code", int'(ratio_code), 2);
    chk("R9 hi_rate", int'(hi_rate), 0);

    // R1 R2 R3 sweep: every ratio, offsets -3..+3
    for (int c = 0; c < 5; c++)
      for (int off = -3; off <= 3; off++) begin
        do_reset();
        for (int f = 0; f < 6; f++) frame(nom_of(c) + off);
      end

    // R4 R5: change ratio after lock; mode must hold until relock
    do_reset();
    for (int f = 0; f < 6; f++) frame(128);
    for (int f = 0; f < 6; f++) frame(256);
    for (int f = 0; f < 6; f++) frame(193);

    // R4: one unsupported frame while locked
    do_reset();
    for (int f = 0; f < 6; f++) frame(384);
    frame(300);
    for (int f = 0; f < 6; f++) frame(384);

    // R3: alternating ratios never lock
    do_reset();
    for (int f = 0; f < 4; f++) begin frame(192); frame(512); end

    // R2: over-long frame saturates and is unsupported
    do_reset();
    for (int f = 0; f < 5; f++) frame(510);
    frame(1100);
    frame(512);
    for (int f = 0; f < 5; f++) frame(512);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule